// File: doc/BRIEF.md
# Processor-Mode Memory Map Decoder

This block decodes every CPU bus access of an 8-bit controller with a 16-bit address space and steers it to the right target. The targets are the special-function registers, internal RAM, internal ROM and the external bus. Accesses to reserved or unreachable addresses raise a fault instead. It keeps the processor mode in a small state machine with three states: `MODE_SINGLE` (no external bus), `MODE_EXPAND` (internal memory plus external bus) and `MODE_MICRO` (external bus also replaces internal ROM).

State transitions:
- Any state goes to the coded state when the mode control address is written with a legal code.
- Any state goes to `MODE_MICRO` while the mode strap is high.
- A write of code 11 leaves the state unchanged.

Decode results are registered and appear one clock after the strobe. The decode uses the mode that was in force before that clock edge. In both external modes, a write to internal RAM is copied onto the external bus. The port data and direction registers at the bottom of the register area move off-chip in those modes.

Top module: `mmap_decoder`

## Requirements
- R1: While reset is asserted, `mode_o` is 00 (single-chip) if `mode_strap` is low and 10 (microprocessor) if it is high, and all select and fault outputs are 0.
- R2: A write strobe with address 0x0000 loads `mode_wdata` into the mode at that clock edge (00 single-chip, 01 expansion, 10 microprocessor), so `mode_o` shows it immediately afterwards; code 11 leaves the mode unchanged.
- R3: While `mode_strap` is high, the mode becomes 10 at the next edge and no mode write can change it.
- R4: Addresses 0x0000–0x006F raise `sel_sfr`, except 0x0008–0x000F in modes 01 and 10, which raise `ext_en` only.
- R5: Addresses 0x0070–0x046F raise `sel_ram`; in modes 01 and 10 a write also raises `ext_en`, a read does not.
- R6: Addresses 0x0470–0x7FFF raise `fault` in mode 00 and `ext_en` in modes 01 and 10.
- R7: Addresses 0x8000–0x807F and 0xFFFC–0xFFFF raise `fault` in every mode.
- R8: Addresses 0x8080–0xFFFB raise `sel_rom` in modes 00 and 01 and `ext_en` in mode 10.
- R9: Outputs are registered: they reflect the strobe of the previous cycle, are all 0 after a cycle with no strobe, and a fault lasts exactly one cycle.
- R10: At most one of `sel_sfr`, `sel_ram`, `sel_rom`, `fault` is high, and `fault` never appears with `ext_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| mode_wdata | input | 2 | Data bits 1:0 for a mode write |
| mode_strap | input | 1 | Strap forcing microprocessor mode |
| sel_sfr | output | 1 | Register-area select |
| sel_ram | output | 1 | Internal RAM select |
| sel_rom | output | 1 | Internal ROM select |
| ext_en | output | 1 | External bus access enable |
| fault | output | 1 | Access fault pulse |
| mode_o | output | 2 | Current processor mode |

## Verification
A wrong mode state shows up in `mode_o` in the cycle after the edge that caused it. It also shows in the following access, in three ways: a ROM access goes external, a high-memory access faults, or a port register access stays internal. Sweeps of the address space in each of the three modes, for both reads and writes, expose a misplaced region boundary within one access. Strap and illegal-code sequences expose a transition taken in the wrong direction within one cycle.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_EXPAND = 2'b01,
        MODE_MICRO  = 2'b10
    } mode_e;

    typedef struct packed {
        logic sfr;
        logic ram;
        logic rom;
        logic ext;
        logic fault;
    } route_t;

endpackage

// File: rtl/mmap_mode_fsm.sv
module mmap_mode_fsm
    import mmap_pkg::*;
#(
    parameter int AW        = 16,
    parameter int CTRL_ADDR = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    wdata,
    output mode_e         mode
);

    localparam logic [AW-1:0] CTRL = AW'(CTRL_ADDR);

    mode_e state, state_nxt;
    logic  wr_hit;

    assign wr_hit = wr_en && (addr == CTRL);

    always_comb begin
        state_nxt = state;
        if (strap) begin
            state_nxt = MODE_MICRO;
        end else if (wr_hit) begin
            unique case (wdata)
                2'b00:   state_nxt = MODE_SINGLE;
                2'b01:   state_nxt = MODE_EXPAND;
                2'b10:   state_nxt = MODE_MICRO;
                default: state_nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= strap ? MODE_MICRO : MODE_SINGLE;
        else        state <= state_nxt;
    end

    always_comb begin
        mode = state;
    end

    // R3
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap |=> (mode == MODE_MICRO));

    // R2
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !strap && wdata == 2'b11) |=> $stable(mode));

endmodule

// File: rtl/mmap_region_decode.sv
module mmap_region_decode
    import mmap_pkg::*;
#(
    parameter int AW       = 16,
    parameter int SFR_END  = 'h006F,
    parameter int PORT_LO  = 'h0008,
    parameter int PORT_HI  = 'h000F,
    parameter int RAM_END  = 'h046F,
    parameter int EXT_END  = 'h7FFF,
    parameter int RSV_END  = 'h807F,
    parameter int ROM_END  = 'hFFFB
) (
    input  mode_e         mode,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    output route_t        route
);

    localparam logic [AW-1:0] A_SFR  = AW'(SFR_END);
    localparam logic [AW-1:0] A_PLO  = AW'(PORT_LO);
    localparam logic [AW-1:0] A_PHI  = AW'(PORT_HI);
    localparam logic [AW-1:0] A_RAM  = AW'(RAM_END);
    localparam logic [AW-1:0] A_EXT  = AW'(EXT_END);
    localparam logic [AW-1:0] A_RSV  = AW'(RSV_END);
    localparam logic [AW-1:0] A_ROM  = AW'(ROM_END);

    logic off_chip;

    always_comb begin
        route    = '0;
        off_chip = (mode != MODE_SINGLE);
        if (rd_en || wr_en) begin
            if (addr <= A_SFR) begin
                if (off_chip && addr >= A_PLO && addr <= A_PHI) route.ext = 1'b1;
                else                                            route.sfr = 1'b1;
            end else if (addr <= A_RAM) begin
                route.ram = 1'b1;
                route.ext = off_chip && wr_en;
            end else if (addr <= A_EXT) begin
                if (off_chip) route.ext   = 1'b1;
                else          route.fault = 1'b1;
            end else if (addr <= A_RSV) begin
                route.fault = 1'b1;
            end else if (addr <= A_ROM) begin
                unique case (mode)
                    MODE_MICRO: route.ext = 1'b1;
                    default:    route.rom = 1'b1;
                endcase
            end else begin
                route.fault = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [1:0]    mode_wdata,
    input  logic          mode_strap,
    output logic          sel_sfr,
    output logic          sel_ram,
    output logic          sel_rom,
    output logic          ext_en,
    output logic          fault,
    output logic [1:0]    mode_o
);

    mode_e  mode;
    route_t route_d, route_q;

    mmap_mode_fsm #(.AW(AW), .CTRL_ADDR(0)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (mode_strap),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (mode_wdata),
        .mode  (mode)
    );

    mmap_region_decode #(.AW(AW)) u_dec (
        .mode  (mode),
        .addr  (addr),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .route (route_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) route_q <= '0;
        else        route_q <= route_d;
    end

    always_comb begin
        sel_sfr = route_q.sfr;
        sel_ram = route_q.ram;
        sel_rom = route_q.rom;
        ext_en  = route_q.ext;
        fault   = route_q.fault;
        mode_o  = mode;
    end

    // R10
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_sfr, sel_ram, sel_rom, fault}) && !(fault && ext_en));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> !(sel_sfr || sel_ram || sel_rom || ext_en || fault));

    // R5
    ram_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ram && ext_en) |-> $past(wr_en));

    // R8
    rom_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rom |-> ($past(mode) != MODE_MICRO));

endmodule

// File: tb/mmap_decoder_bench.sv
`timescale 1ns/1ps
module mmap_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  mode_wdata = '0;
    logic        mode_strap = 1'b0;
    logic        sel_sfr, sel_ram, sel_rom, ext_en, fault;
    logic [1:0]  mode_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mmap_decoder u_mmap_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .mode_wdata(mode_wdata), .mode_strap(mode_strap),
        .sel_sfr(sel_sfr), .sel_ram(sel_ram), .sel_rom(sel_rom),
        .ext_en(ext_en), .fault(fault), .mode_o(mode_o)
    );

    function automatic logic [4:0] expect_of(input logic [1:0] m, input int a, input bit wr);
        bit offc = (m != 2'b00);
        if (a <= 'h6F)        return (offc && a >= 8 && a <= 15) ? 5'b00010 : 5'b10000;
        if (a <= 'h46F)       return (offc && wr) ? 5'b01010 : 5'b01000;
        if (a <= 'h7FFF)      return offc ? 5'b00010 : 5'b00001;
        if (a <= 'h807F)      return 5'b00001;
        if (a <= 'hFFFB)      return (m == 2'b10) ? 5'b00010 : 5'b00100;
        return 5'b00001;
    endfunction

    function automatic string tag_of(input int a);
        if (a <= 'h6F)   return "R4";
        if (a <= 'h46F)  return "R5";
        if (a <= 'h7FFF) return "R6";
        if (a <= 'h807F || a >= 'hFFFC) return "R7";
        return "R8";
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {sel_sfr, sel_ram, sel_rom, ext_en, fault};
    endfunction

    // called at a falling edge; returns at the next falling edge with inputs idle
    task automatic access(input int a, input bit wr, input logic [1:0] m);
        addr = 16'(a); rd_en = !wr; wr_en = wr;
        @(negedge clk);
        check(tag_of(a), outs(), expect_of(m, a, wr));
        check("R10", ($countones({sel_sfr, sel_ram, sel_rom, fault}) <= 1 && !(fault && ext_en)), 1);
        rd_en = 0; wr_en = 0;
    endtask

    task automatic set_mode(input logic [1:0] code, input logic [1:0] exp_mode);
        addr = 16'h0000; wr_en = 1; mode_wdata = code;
        @(negedge clk);
        check("R2", mode_o, exp_mode);
        wr_en = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state, strap low
        #5;
        check("R1", {mode_o, outs()}, 7'b0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check("R1", mode_o, 2'b00);

        // R9 idle cycle and one-cycle fault
        @(negedge clk);
        check("R9", outs(), 0);
        access('h8000, 0, 2'b00);
        @(negedge clk);
        check("R9", fault, 0);

        // sweeps in each mode
        for (int mi = 0; mi < 3; mi++) begin
            logic [1:0] m = 2'(mi);
            set_mode(m, m);
            for (int a = 1; a < 65536; a += 37) begin
                access(a, 0, m);
                access(a, 1, m);
            end
            for (int k = 0; k < 14; k++) begin
                int b;
                case (k)
                    0: b = 'h0007;  1: b = 'h0008;  2: b = 'h000F;  3: b = 'h0010;
                    4: b = 'h006F;  5: b = 'h0070;  6: b = 'h046F;  7: b = 'h0470;
                    8: b = 'h7FFF;  9: b = 'h8000; 10: b = 'h807F; 11: b = 'h8080;
                    12: b = 'hFFFB; default: b = 'hFFFC;
                endcase
                access(b, 0, m);
                access(b, 1, m);
            end
            access('hFFFF, 0, m);
        end

        // R2 illegal code ignored
        set_mode(2'b01, 2'b01);
        set_mode(2'b11, 2'b01);
        access('h8100, 0, 2'b01);

        // R3 strap forces microprocessor mode
        mode_strap = 1;
        @(negedge clk);
        check("R3", mode_o, 2'b10);
        addr = 0; wr_en = 1; mode_wdata = 2'b00;
        @(negedge clk);
        check("R3", mode_o, 2'b10);
        wr_en = 0;
        access('h9000, 0, 2'b10);
        mode_strap = 0;
        set_mode(2'b00, 2'b00);

        // R1 reset with strap high
        mode_strap = 1;
        #1 rst_n = 0;
        #1 check("R1", {mode_o, outs()}, 7'b1000000);
        @(negedge clk); rst_n = 1;
        mode_strap = 0;
        @(negedge clk);
        check("R1", mode_o, 2'b10);
        access('hC000, 0, 2'b10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule